// File: doc/BRIEF.md
# Breakpoint Trigger Fire Gate

This block sits between a set of hardware debug trigger comparators and the exception request stage of a processor pipeline. For each trigger it takes the raw match and the trigger's action code. It then decides whether that match may fire. Triggers whose action is "raise a breakpoint exception" (action code zero) are held back in the privilege states where a breakpoint handler would otherwise trip over its own trigger. Every other action passes untouched.

The hold-back rule depends on a configuration flag that says whether supervisor mode exists.

- **Supervisor mode present.** The rule uses the current privilege level, the virtualization bit, three interrupt-enable bits and the breakpoint-delegation bit of the machine and hypervisor delegation registers.
- **Supervisor mode absent.** A small trigger-control register takes the place of that check. It holds an enable and a saved copy of the enable. A trap into machine mode saves the enable and clears it, and a machine trap return restores it. Software reads and writes the register through a simple CSR port.

The qualified fire-enable vector is registered. It therefore lines up with the exception request stage one cycle after the match.

Top module: `dbg_trig_fire_gate`

## Requirements
- R1: A trigger whose action code is nonzero (any bit of its ACT_W-bit field set) fires exactly when it matched, whatever the privilege state, enables, delegation or trigger-control contents.
- R2: With s_mode_present=1 and priv=2'b11 (machine), an action-zero trigger is blocked when m_ie=0 and fires on a match when m_ie=1.
- R3: With s_mode_present=1, priv=2'b01 and virt=0, an action-zero trigger is blocked exactly when m_deleg_bp=1 and s_ie=0. The bit m_deleg_bp is bit 3 of the machine delegation register, which is the breakpoint cause code.
- R4: With s_mode_present=1, priv=2'b01 and virt=1, an action-zero trigger is blocked exactly when m_deleg_bp=1, h_deleg_bp=1 and vs_ie=0. The bit h_deleg_bp is bit 3 of the hypervisor delegation register.
- R5: With s_mode_present=0, an action-zero trigger in machine mode is blocked exactly when the enable bit of the trigger-control register is 0. In any other privilege level it is never blocked. In this configuration the delegation and interrupt-enable inputs have no effect.
- R6: In priv=2'b00 (user, including virtual user when virt=1), no blocking applies, and each fire-enable bit equals its match.
- R7: On trap_to_m, the saved-enable bit takes the current enable value and the enable bit becomes 0.
- R8: On trap_ret_m without trap_to_m, the enable bit takes the saved-enable value, and the saved-enable bit is unchanged.
- R9: Trigger-control register layout and update priority:
  - The enable bit is csr bit 3 and the saved-enable bit is csr bit 7.
  - All other csr bits read 0 and ignore writes.
  - Reset clears both bits.
  - trap_to_m has priority over trap_ret_m, which has priority over csr_we.
- R10: fire_en is registered. It reflects the inputs and register state at the previous rising clock edge, and it is 0 during and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_mode_present | input | 1 | Supervisor mode implemented |
| priv | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| virt | input | 1 | Virtualization mode active |
| m_ie | input | 1 | Machine interrupt enable |
| s_ie | input | 1 | Supervisor interrupt enable |
| vs_ie | input | 1 | Virtual supervisor interrupt enable |
| m_deleg_bp | input | 1 | Machine delegation register bit 3 |
| h_deleg_bp | input | 1 | Hypervisor delegation register bit 3 |
| trap_to_m | input | 1 | Trap into machine mode this cycle |
| trap_ret_m | input | 1 | Machine trap return this cycle |
| csr_we | input | 1 | Trigger-control register write strobe |
| csr_wdata | input | CTRL_W | Trigger-control write data |
| csr_rdata | output | CTRL_W | Trigger-control read data |
| trig_match | input | NUM_TRIG | Raw match per trigger |
| trig_action | input | NUM_TRIG*ACT_W | Action code per trigger, trigger i at bits [i*ACT_W +: ACT_W] |
| fire_en | output | NUM_TRIG | Registered fire qualifier per trigger |

## Verification
The results do not all appear on the same cycle:

- **fire_en** is due one rising edge after the match, action and privilege inputs that produce it. It uses the trigger-control enable as it stood before that edge.
- **csr_rdata** shows a trap, trap-return or write on the same edge that performs it.

The bench changes inputs on the falling edge and samples both outputs on the next falling edge. At that point it compares them with a model that evaluates the blocking rule on the pre-edge enable and then applies the register update. Random privilege, enable, delegation and action mixes are joined by directed write, trap and return cases.

// File: rtl/dtf_pkg.sv
package dtf_pkg;
  localparam int unsigned MTE_POS  = 3;
  localparam int unsigned MPTE_POS = 7;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;

  typedef struct packed {
    logic mpte;
    logic mte;
  } tctrl_t;
endpackage

// File: rtl/dtf_ctrl_reg.sv
module dtf_ctrl_reg
  import dtf_pkg::*;
#(
  parameter int unsigned CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_to_m,
  input  logic              trap_ret_m,
  input  logic              csr_we,
  input  logic [CTRL_W-1:0] csr_wdata,
  output logic [CTRL_W-1:0] csr_rdata,
  output tctrl_t            ctl_q
);
  tctrl_t ctl_d;
  logic   ctl_en;
  logic   unused_wdata;

  assign unused_wdata = ^csr_wdata;
  assign ctl_en = trap_to_m | trap_ret_m | csr_we;

  always_comb begin
    ctl_d = ctl_q;
    if (trap_to_m) begin
      ctl_d.mpte = ctl_q.mte;
      ctl_d.mte  = 1'b0;
    end else if (trap_ret_m) begin
      ctl_d.mte  = ctl_q.mpte;
    end else if (csr_we) begin
      ctl_d.mte  = csr_wdata[MTE_POS];
      ctl_d.mpte = csr_wdata[MPTE_POS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  always_comb begin
    csr_rdata           = '0;
    csr_rdata[MTE_POS]  = ctl_q.mte;
    csr_rdata[MPTE_POS] = ctl_q.mpte;
  end
endmodule

// File: rtl/dtf_inhibit_eval.sv
module dtf_inhibit_eval
  import dtf_pkg::*;
(
  input  logic       s_mode_present,
  input  logic [1:0] priv,
  input  logic       virt,
  input  logic       m_ie,
  input  logic       s_ie,
  input  logic       vs_ie,
  input  logic       m_deleg_bp,
  input  logic       h_deleg_bp,
  input  logic       mte,
  output logic       block_bp
);
  logic blk_with_s;
  logic blk_no_s;

  always_comb begin
    blk_with_s = 1'b0;
    unique case (priv)
      PRIV_M:  blk_with_s = ~m_ie;
      PRIV_S:  blk_with_s = virt ? (m_deleg_bp & h_deleg_bp & ~vs_ie)
                                 : (m_deleg_bp & ~s_ie);
      default: blk_with_s = 1'b0;
    endcase
  end

  assign blk_no_s = (priv == PRIV_M) & ~mte;
  assign block_bp = s_mode_present ? blk_with_s : blk_no_s;
endmodule

// File: rtl/dtf_fire_stage.sv
module dtf_fire_stage #(
  parameter int unsigned NUM_TRIG = 4,
  parameter int unsigned ACT_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      block_bp,
  input  logic [NUM_TRIG-1:0]       trig_match,
  input  logic [NUM_TRIG*ACT_W-1:0] trig_action,
  output logic [NUM_TRIG-1:0]       fire_en
);
  logic [NUM_TRIG-1:0] fire_d;

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_trig
    logic is_bp;
    assign is_bp     = (trig_action[i*ACT_W +: ACT_W] == '0);
    assign fire_d[i] = trig_match[i] & ~(is_bp & block_bp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fire_en <= '0;
    else        fire_en <= fire_d;
  end
endmodule

// File: rtl/dbg_trig_fire_gate.sv
module dbg_trig_fire_gate
  import dtf_pkg::*;
#(
  parameter int unsigned NUM_TRIG = 4,
  parameter int unsigned ACT_W    = 4,
  parameter int unsigned CTRL_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      s_mode_present,
  input  logic [1:0]                priv,
  input  logic                      virt,
  input  logic                      m_ie,
  input  logic                      s_ie,
  input  logic                      vs_ie,
  input  logic                      m_deleg_bp,
  input  logic                      h_deleg_bp,
  input  logic                      trap_to_m,
  input  logic                      trap_ret_m,
  input  logic                      csr_we,
  input  logic [CTRL_W-1:0]         csr_wdata,
  output logic [CTRL_W-1:0]         csr_rdata,
  input  logic [NUM_TRIG-1:0]       trig_match,
  input  logic [NUM_TRIG*ACT_W-1:0] trig_action,
  output logic [NUM_TRIG-1:0]       fire_en
);
  tctrl_t ctl_q;
  logic   mte_q;
  logic   mpte_q;
  logic   block_bp;

  assign mte_q  = ctl_q.mte;
  assign mpte_q = ctl_q.mpte;

  dtf_ctrl_reg #(.CTRL_W(CTRL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .trap_to_m(trap_to_m), .trap_ret_m(trap_ret_m),
    .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .ctl_q(ctl_q)
  );

  dtf_inhibit_eval u_eval (
    .s_mode_present(s_mode_present), .priv(priv), .virt(virt),
    .m_ie(m_ie), .s_ie(s_ie), .vs_ie(vs_ie),
    .m_deleg_bp(m_deleg_bp), .h_deleg_bp(h_deleg_bp),
    .mte(mte_q), .block_bp(block_bp)
  );

  dtf_fire_stage #(.NUM_TRIG(NUM_TRIG), .ACT_W(ACT_W)) u_fire (
    .clk(clk), .rst_n(rst_n), .block_bp(block_bp),
    .trig_match(trig_match), .trig_action(trig_action),
    .fire_en(fire_en)
  );
endmodule

// File: rtl/dtf_gate_checker.sv
module dtf_gate_checker
  import dtf_pkg::*;
#(
  parameter int unsigned NUM_TRIG = 4,
  parameter int unsigned ACT_W    = 4,
  parameter int unsigned CTRL_W   = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      s_mode_present,
  input logic [1:0]                priv,
  input logic                      m_ie,
  input logic                      trap_to_m,
  input logic                      trap_ret_m,
  input logic [CTRL_W-1:0]         csr_rdata,
  input logic [NUM_TRIG-1:0]       trig_match,
  input logic [NUM_TRIG*ACT_W-1:0] trig_action,
  input logic [NUM_TRIG-1:0]       fire_en,
  input logic                      mte_q,
  input logic                      mpte_q
);
  localparam logic [CTRL_W-1:0] LIVE_MASK =
    (CTRL_W'(1) << MTE_POS) | (CTRL_W'(1) << MPTE_POS);

  // R10: a fire needs a match on the previous edge
  p_fire_needs_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_en & ~$past(trig_match)) == '0);

  // R1: nonzero action on trigger 0 is never held back
  p_nonbp_passes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_match[0] && trig_action[ACT_W-1:0] != '0) |=> fire_en[0]);

  // R2: machine mode with interrupts off holds back breakpoint trigger 0
  p_mmode_mie_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_mode_present && priv == PRIV_M && !m_ie && trig_action[ACT_W-1:0] == '0)
    |=> !fire_en[0]);

  // R6: user level passes matches straight through
  p_user_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == PRIV_U) |=> (fire_en == $past(trig_match)));

  // R7: trap saves and clears the enable
  p_trap_save_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_to_m |=> (!mte_q && mpte_q == $past(mte_q)));

  // R8: trap return restores the enable
  p_ret_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_ret_m && !trap_to_m) |=> (mte_q == $past(mpte_q) && $stable(mpte_q)));

  // R9: only the two live bits ever read nonzero
  p_dead_bits_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata & ~LIVE_MASK) == '0);
endmodule

bind dbg_trig_fire_gate dtf_gate_checker #(
  .NUM_TRIG(NUM_TRIG), .ACT_W(ACT_W), .CTRL_W(CTRL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .s_mode_present(s_mode_present), .priv(priv),
  .m_ie(m_ie), .trap_to_m(trap_to_m), .trap_ret_m(trap_ret_m),
  .csr_rdata(csr_rdata), .trig_match(trig_match), .trig_action(trig_action),
  .fire_en(fire_en), .mte_q(mte_q), .mpte_q(mpte_q)
);

// File: tb/dbg_trig_fire_gate_test.sv
module dbg_trig_fire_gate_test;
  localparam int unsigned NT = 4;
  localparam int unsigned AW = 4;
  localparam int unsigned CW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic s_mode_present, virt, m_ie, s_ie, vs_ie, m_deleg_bp, h_deleg_bp;
  logic [1:0] priv;
  logic trap_to_m, trap_ret_m, csr_we;
  logic [CW-1:0] csr_wdata, csr_rdata;
  logic [NT-1:0] trig_match, fire_en;
  logic [NT*AW-1:0] trig_action;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic m_mte, m_mpte;
  logic [NT-1:0] exp_fire;
  string fire_tag [NT];
  string rd_tag;

  always #2 clk = ~clk;

  dbg_trig_fire_gate #(.NUM_TRIG(NT), .ACT_W(AW), .CTRL_W(CW)) uut (.*);

  task automatic check(string req, logic [CW-1:0] act, logic [CW-1:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_block(logic sp, logic [1:0] pv, logic vt, logic mi,
                                     logic si, logic vsi, logic md, logic hd, logic en);
    if (!sp) return (pv == 2'b11) && !en;
    if (pv == 2'b11) return !mi;
    if (pv == 2'b01) return vt ? (md && hd && !vsi) : (md && !si);
    return 1'b0;
  endfunction

  function automatic string tag_for(logic nz, logic sp, logic [1:0] pv, logic vt);
    if (nz) return "R1";
    if (pv == 2'b00) return "R6";
    if (!sp) return "R5";
    if (pv == 2'b11) return "R2";
    return vt ? "R4" : "R3";
  endfunction

  // Inputs are set after a falling edge; outputs are checked at the next one.
  task automatic step();
    logic blk;
    blk = exp_block(s_mode_present, priv, virt, m_ie, s_ie, vs_ie,
                    m_deleg_bp, h_deleg_bp, m_mte);
    for (int i = 0; i < NT; i++) begin
      logic nz;
      nz = (trig_action[i*AW +: AW] != '0);
      exp_fire[i] = trig_match[i] && !(!nz && blk);
      fire_tag[i] = tag_for(nz, s_mode_present, priv, virt);
    end
    if (trap_to_m) begin
      m_mpte = m_mte; m_mte = 1'b0; rd_tag = "R7";
    end else if (trap_ret_m) begin
      m_mte = m_mpte; rd_tag = "R8";
    end else if (csr_we) begin
      m_mte = csr_wdata[3]; m_mpte = csr_wdata[7]; rd_tag = "R9";
    end else rd_tag = "R9";
    @(negedge clk);
    for (int i = 0; i < NT; i++)
      check(fire_tag[i], CW'(fire_en[i]), CW'(exp_fire[i]), $sformatf("fire_en[%0d]", i));
    check(rd_tag, csr_rdata, {m_mpte, 3'b000, m_mte, 3'b000}, "csr_rdata");
  endtask

  task automatic idle_inputs();
    s_mode_present = 1'b1; priv = 2'b11; virt = 1'b0;
    m_ie = 1'b0; s_ie = 1'b0; vs_ie = 1'b0; m_deleg_bp = 1'b0; h_deleg_bp = 1'b0;
    trap_to_m = 1'b0; trap_ret_m = 1'b0; csr_we = 1'b0; csr_wdata = '0;
    trig_match = '0; trig_action = '0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_inputs();
    m_mte = 1'b0; m_mpte = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10 and R9: reset state
    check("R10", CW'(fire_en), '0, "fire_en in reset");
    check("R9", csr_rdata, '0, "csr_rdata in reset");
    rst_n = 1'b1;
    trig_match = '1;
    step();  // machine mode, MIE=0, action zero: blocked (R2)

    // R9: write all ones, only bits 3 and 7 stick
    idle_inputs(); csr_we = 1'b1; csr_wdata = 8'hFF; step();
    // R5: no S-mode, machine mode, enable set -> fires
    idle_inputs(); s_mode_present = 1'b0; trig_match = '1; step();
    // R7: trap saves enable and clears it, trap beats write (R9 priority)
    idle_inputs(); trap_to_m = 1'b1; trap_ret_m = 1'b1; csr_we = 1'b1; step();
    // R5: enable now clear -> blocked; nonzero action on trigger 2 passes (R1)
    idle_inputs(); s_mode_present = 1'b0; m_ie = 1'b1; m_deleg_bp = 1'b1;
    trig_match = '1; trig_action[2*AW +: AW] = 4'h2; step();
    // R8: return restores, beating a write
    idle_inputs(); trap_ret_m = 1'b1; csr_we = 1'b1; csr_wdata = 8'h00; step();
    // R4: virtual supervisor, both delegations, vs_ie=0 -> blocked
    idle_inputs(); priv = 2'b01; virt = 1'b1; m_deleg_bp = 1'b1; h_deleg_bp = 1'b1;
    s_ie = 1'b0; trig_match = '1; step();
    // R6: virtual user passes
    idle_inputs(); priv = 2'b00; virt = 1'b1; trig_match = 4'b1010; step();

    for (int n = 0; n < 800; n++) begin
      int r;
      idle_inputs();
      s_mode_present = ($urandom_range(0, 3) != 0);
      r = $urandom_range(0, 2);
      priv = (r == 0) ? 2'b00 : (r == 1) ? 2'b01 : 2'b11;
      virt = $urandom_range(0, 1);
      m_ie = $urandom_range(0, 1); s_ie = $urandom_range(0, 1);
      vs_ie = $urandom_range(0, 1);
      m_deleg_bp = $urandom_range(0, 1); h_deleg_bp = $urandom_range(0, 1);
      trap_to_m = ($urandom_range(0, 7) == 0);
      trap_ret_m = ($urandom_range(0, 7) == 0);
      csr_we = ($urandom_range(0, 3) == 0);
      csr_wdata = CW'($urandom);
      trig_match = NT'($urandom);
      for (int i = 0; i < NT; i++)
        trig_action[i*AW +: AW] = ($urandom_range(0, 1) == 0) ? '0 : AW'($urandom_range(1, 15));
      step();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule